// File: doc/BRIEF.md
# Three-Slot Receive Buffer Manager with Arrival-Order Tags

This block sits between a bus receiver and a host. Each time the receiver reports a finished incoming message, the block stores the payload in a free slot. It picks the free slot with the lowest index. It then tags that slot with a 2-bit arrival-order value and sets the slot's ready bit. A per-slot mask decides whether a ready slot drives the host interrupt.

The host reads the tags to find the oldest unread message, whatever the slot index. When it has read a message, it pulses that slot's clear strobe. When slots are freed, the tags of the slots still holding data are renumbered so that they run from 1 upward in arrival order.

While all three slots hold unread data, new messages are discarded and a sticky overflow flag is raised. Within one clock, clear strobes take effect before a new message is placed. A slot freed in a cycle can therefore take a message arriving in that same cycle.

Top module: `rxbuf_mgr`

## Requirements
- R1: After reset, `bufReady`, `bufStamp`, `allFull`, `overflow` and `irq` are all zero.
- R2: A message accepted on a clock edge goes to the lowest-indexed slot that is free after that edge's clears are applied.
- R3: A newly stored message receives tag value k+1, where k is the number of slots still occupied after that edge's clears. Slot n's tag is `bufStamp[2n+1:2n]`.
- R4: A clear strobe on an occupied slot drops its ready bit and sets its tag to 0 at the same edge, unless a message is stored into that slot at that edge. An empty slot always shows tag 0.
- R5: After any edge, the occupied slots carry tags 1 to k, with no gaps. Their order matches the order in which their messages arrived.
- R6: A message that arrives while no slot is free after clears is discarded. Ready bits, tags and payloads stay unchanged. `overflow` goes to 1 and stays at 1 until reset.
- R7: `irq` is high exactly when some slot has both its ready bit and its `irqMask` bit set. It follows mask changes without a clock.
- R8: Clear strobes for several slots in the same cycle all take effect at once. The remaining tags are compacted in that single edge.
- R9: A clear and a message in the same cycle on a full block free the slot and store the new message there.
- R10: Slot n's payload is `bufPayload[n*DATA_W +: DATA_W]`. It equals `msgData` as sampled at the edge where the slot was filled, and it holds until the slot is filled again.
- R11: A clear strobe on an empty slot changes no output.
- R12: `allFull` is high exactly when all three ready bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | One-cycle pulse: a complete message is present on msgData |
| msgData | input | DATA_W | Payload of the finished message |
| clearStb | input | 3 | Per-slot release strobes from the host |
| irqMask | input | 3 | Per-slot interrupt enables |
| bufReady | output | 3 | Per-slot unread-data flags |
| bufStamp | output | 6 | Packed 2-bit arrival tags, slot n at bits 2n+1:2n |
| bufPayload | output | 3*DATA_W | Packed stored payloads, slot n at n*DATA_W |
| allFull | output | 1 | All slots occupied |
| overflow | output | 1 | Sticky: a message was discarded |
| irq | output | 1 | Host interrupt |

## Verification
The checker watches several tag invariants on every cycle. Every occupied slot holds a tag between 1 and the occupancy count, no two occupied slots share a tag, and empty slots read 0. It also checks that an input while full freezes the state and sets the sticky flag, that a clear without a message empties its slot, and that a masked-off block never interrupts.

Some properties depend on history and can only be shown by the bench's scenarios. These are the exact renumbering after each release, the preservation of arrival order across out-of-order reuse, the outcome of simultaneous clears with a message, and the payload each slot retains.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int NUM_BUF = 3;
  localparam int STAMP_W = $clog2(NUM_BUF + 1);

  typedef logic [STAMP_W-1:0] stamp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_BUF-1:0] load;   // capture msgData into slot
    logic               accept; // message taken this cycle
  } dp_ctrl_t;
endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       msgValid,
  input  logic [NUM_BUF-1:0]         clearStb,
  output logic [NUM_BUF-1:0]         occupied,
  output logic [NUM_BUF*STAMP_W-1:0] stampFlat,
  output logic                       ovfFlag,
  output dp_ctrl_t                   dpCtrl
);
  stamp_t             stampQ   [NUM_BUF];
  stamp_t             stampD   [NUM_BUF];
  stamp_t             rankV    [NUM_BUF];
  logic [NUM_BUF-1:0] occQ, occD;
  logic [NUM_BUF-1:0] keepMask, freeMask, loadOne;
  stamp_t             keepCount;
  logic               found, anyFree, ovfQ;

  // clears first, then allocation over the remaining free slots
  always_comb begin
    keepMask  = occQ & ~clearStb;
    freeMask  = ~keepMask;
    anyFree   = |freeMask;
    keepCount = '0;
    for (int i = 0; i < NUM_BUF; i++)
      keepCount = keepCount + STAMP_W'(keepMask[i]);
    loadOne = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (freeMask[i] && !found) begin
        loadOne[i] = msgValid;
        found      = 1'b1;
      end
    end
  end

  // rank of each surviving slot among survivors (oldest = 1)
  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      rankV[i] = STAMP_W'(1);
      for (int j = 0; j < NUM_BUF; j++) begin
        if (j != i && keepMask[j] && stampQ[j] < stampQ[i])
          rankV[i] = rankV[i] + STAMP_W'(1);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      if (loadOne[i])       stampD[i] = keepCount + STAMP_W'(1);
      else if (keepMask[i]) stampD[i] = rankV[i];
      else                  stampD[i] = '0;
    end
    occD = keepMask | loadOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ <= '0;
      ovfQ <= 1'b0;
      for (int i = 0; i < NUM_BUF; i++) stampQ[i] <= '0;
    end else begin
      occQ <= occD;
      if (msgValid && !anyFree) ovfQ <= 1'b1;
      for (int i = 0; i < NUM_BUF; i++) stampQ[i] <= stampD[i];
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : gStamp
    assign stampFlat[g*STAMP_W +: STAMP_W] = stampQ[g];
  end

  assign occupied      = occQ;
  assign ovfFlag       = ovfQ;
  assign dpCtrl.load   = loadOne;
  assign dpCtrl.accept = msgValid && anyFree;
endmodule

// File: rtl/rxbuf_data.sv
module rxbuf_data
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DATA_W-1:0]         msgData,
  input  dp_ctrl_t                  dpCtrl,
  output logic [NUM_BUF*DATA_W-1:0] payloadFlat
);
  for (genvar g = 0; g < NUM_BUF; g++) begin : gSlot
    logic [DATA_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ <= '0;
      else if (dpCtrl.accept && dpCtrl.load[g])
        slotQ <= msgData;
    end
    assign payloadFlat[g*DATA_W +: DATA_W] = slotQ;
  end
endmodule

// File: rtl/rxbuf_mgr.sv
module rxbuf_mgr
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      msgValid,
  input  logic [DATA_W-1:0]         msgData,
  input  logic [NUM_BUF-1:0]        clearStb,
  input  logic [NUM_BUF-1:0]        irqMask,
  output logic [NUM_BUF-1:0]        bufReady,
  output logic [NUM_BUF*STAMP_W-1:0] bufStamp,
  output logic [NUM_BUF*DATA_W-1:0] bufPayload,
  output logic                      allFull,
  output logic                      overflow,
  output logic                      irq
);
  dp_ctrl_t dpCtrl;

  rxbuf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .msgValid (msgValid),
    .clearStb (clearStb),
    .occupied (bufReady),
    .stampFlat(bufStamp),
    .ovfFlag  (overflow),
    .dpCtrl   (dpCtrl)
  );

  rxbuf_data #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .msgData    (msgData),
    .dpCtrl     (dpCtrl),
    .payloadFlat(bufPayload)
  );

  assign allFull = &bufReady;
  assign irq     = |(bufReady & irqMask);
endmodule

// File: rtl/rxbuf_mgr_chk.sv
module rxbuf_mgr_chk
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       msgValid,
  input logic [NUM_BUF-1:0]         clearStb,
  input logic [NUM_BUF-1:0]         irqMask,
  input logic [NUM_BUF-1:0]         bufReady,
  input logic [NUM_BUF*STAMP_W-1:0] bufStamp,
  input logic [NUM_BUF*DATA_W-1:0]  bufPayload,
  input logic                       allFull,
  input logic                       overflow,
  input logic                       irq
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : gOne
    // R4: empty slot shows tag zero
    a_r4_empty_tag_zero: assert property (@(posedge clk) disable iff (!rstN)
      !bufReady[i] |-> bufStamp[i*STAMP_W +: STAMP_W] == '0);
    // R5: occupied tag within 1..occupancy
    a_r5_tag_in_range: assert property (@(posedge clk) disable iff (!rstN)
      bufReady[i] |-> (bufStamp[i*STAMP_W +: STAMP_W] != '0) &&
        (int'(bufStamp[i*STAMP_W +: STAMP_W]) <= $countones(bufReady)));
    // R4: clear without an incoming message empties the slot
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
      clearStb[i] && !msgValid |=> !bufReady[i]);
    for (genvar j = i + 1; j < NUM_BUF; j++) begin : gPair
      // R5: no two occupied slots share a tag
      a_r5_tags_distinct: assert property (@(posedge clk) disable iff (!rstN)
        bufReady[i] && bufReady[j] |->
          bufStamp[i*STAMP_W +: STAMP_W] != bufStamp[j*STAMP_W +: STAMP_W]);
    end
  end

  // R6: full with no release discards and freezes the state
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    allFull && msgValid && clearStb == '0 |=>
      $stable(bufReady) && $stable(bufStamp) && $stable(bufPayload) && overflow);
  // R6: overflow is sticky
  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R2: first message into an empty block lands in slot 0 with tag 1
  a_r2_first_slot: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && bufReady == '0 |=> bufReady == 3'b001 && bufStamp == 6'b000001);
  // R7: fully masked block never interrupts
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    irqMask == '0 |-> !irq);
endmodule

bind rxbuf_mgr rxbuf_mgr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .clearStb(clearStb),
  .irqMask(irqMask), .bufReady(bufReady), .bufStamp(bufStamp),
  .bufPayload(bufPayload), .allFull(allFull), .overflow(overflow), .irq(irq)
);

// File: tb/rxbuf_mgr_tb.sv
module rxbuf_mgr_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          msgValid = 1'b0;
  logic [DW-1:0] msgData = '0;
  logic [2:0]    clearStb = '0;
  logic [2:0]    irqMask = '0;
  logic [2:0]    bufReady;
  logic [5:0]    bufStamp;
  logic [3*DW-1:0] bufPayload;
  logic          allFull, overflow, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxbuf_mgr #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgData(msgData),
    .clearStb(clearStb), .irqMask(irqMask), .bufReady(bufReady),
    .bufStamp(bufStamp), .bufPayload(bufPayload), .allFull(allFull),
    .overflow(overflow), .irq(irq)
  );

  typedef struct {
    logic [2:0]    rdy;
    logic [5:0]    st;
    logic          af;
    logic          ov;
    logic          ir;
    logic [3*DW-1:0] pl;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int   ord[$];          // slot indices, oldest first
  logic [DW-1:0] mdl[3];
  bit   mOv = 1'b0;

  task automatic step(input bit v, input logic [DW-1:0] d, input logic [2:0] clr,
                      input logic [2:0] m, input string tag);
    exp_t e;
    @(negedge clk);
    msgValid = v; msgData = d; clearStb = clr; irqMask = m;
    for (int k = ord.size() - 1; k >= 0; k--)
      if (clr[ord[k]]) ord.delete(k);
    if (v) begin
      if (ord.size() < 3) begin
        int f = -1;
        for (int b = 0; b < 3; b++) begin
          bit used = 1'b0;
          foreach (ord[k]) if (ord[k] == b) used = 1'b1;
          if (!used && f < 0) f = b;
        end
        ord.push_back(f);
        mdl[f] = d;
      end else mOv = 1'b1;
    end
    e.rdy = '0; e.st = '0; e.pl = '0;
    foreach (ord[k]) begin
      e.rdy[ord[k]] = 1'b1;
      e.st[2*ord[k] +: 2] = 2'(k + 1);
      e.pl[DW*ord[k] +: DW] = mdl[ord[k]];
    end
    e.af  = (ord.size() == 3);
    e.ov  = mOv;
    e.ir  = |(e.rdy & m);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [3*DW-1:0] plAct;
        e = expQ.pop_front();
        plAct = '0;
        for (int b = 0; b < 3; b++)
          if (e.rdy[b]) plAct[DW*b +: DW] = bufPayload[DW*b +: DW];
        checks++;
        if (bufReady !== e.rdy || bufStamp !== e.st || allFull !== e.af ||
            overflow !== e.ov || irq !== e.ir || plAct !== e.pl) begin
          errors++;
          $display("FAIL %s: rdy=%b st=%b full=%b ovf=%b irq=%b pl=%h exp rdy=%b st=%b full=%b ovf=%b irq=%b pl=%h",
                   e.tag, bufReady, bufStamp, allFull, overflow, irq, plAct,
                   e.rdy, e.st, e.af, e.ov, e.ir, e.pl);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (bufReady !== 3'b0 || bufStamp !== 6'b0 || allFull !== 1'b0 ||
        overflow !== 1'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: rdy=%b st=%b full=%b ovf=%b irq=%b expected all zero",
               bufReady, bufStamp, allFull, overflow, irq);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (bufReady !== 3'b0 || bufStamp !== 6'b0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: rdy=%b st=%b irq=%b expected 0", bufReady, bufStamp, irq);
    end

    // R2 R3 R7 R10 R12: fill in order, interrupt masked on slot 1
    step(1, 16'hA001, 3'b000, 3'b101, "R2 R3 R10 first store");
    step(0, 16'h0000, 3'b000, 3'b010, "R7 mask excludes slot0");
    step(1, 16'hA002, 3'b000, 3'b010, "R2 R3 R7 second store");
    step(1, 16'hA003, 3'b000, 3'b000, "R3 R12 third store full");
    // R6: drop while full
    step(1, 16'hDEAD, 3'b000, 3'b111, "R6 drop when full");
    step(0, 16'h0000, 3'b000, 3'b111, "R6 sticky overflow");
    // R4 R5: free oldest (slot 0), survivors renumbered
    step(0, 16'h0000, 3'b001, 3'b111, "R4 R5 clear oldest compacts");
    // R2 R3: reuse slot 0 as newest
    step(1, 16'hB004, 3'b000, 3'b111, "R2 R3 reuse slot0 newest");
    // R5: free middle-aged slot 2
    step(0, 16'h0000, 3'b100, 3'b100, "R5 clear middle compacts");
    step(1, 16'hB005, 3'b000, 3'b100, "R2 R3 R7 fill slot2");
    // R8: two clears at once
    step(0, 16'h0000, 3'b011, 3'b111, "R8 double clear");
    step(1, 16'hC006, 3'b000, 3'b111, "R2 R3 after double clear");
    step(1, 16'hC007, 3'b000, 3'b111, "R2 R12 full again");
    // R9: clear and message in the same cycle on a full block
    step(1, 16'hC008, 3'b010, 3'b111, "R9 clear with message");
    // R11: clear empty slot after emptying everything
    step(0, 16'h0000, 3'b111, 3'b111, "R4 R8 clear all");
    step(0, 16'h0000, 3'b010, 3'b111, "R11 clear empty slot");
    step(1, 16'hD009, 3'b000, 3'b001, "R2 R3 restart at slot0");
    step(0, 16'h0000, 3'b100, 3'b001, "R11 clear empty while occupied");
    step(0, 16'h0000, 3'b000, 3'b000, "R7 mask off");
    step(0, 16'h0000, 3'b000, 3'b000, "R10 payload held");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule